// File: doc/BRIEF.md
# Serial Bit Streamer with Ninth-Step Quirk

This block takes a parallel byte from a write strobe and plays it out on a single serial pin, one bit for every two clocks, most significant bit first. It is meant for raster and text patterns sent to a beam-blanking line. Once a byte is written, the first bit appears after a fixed start latency of two clocks. When the quirk input is set, the block makes a ninth step that sends the most significant bit a second time. A byte then lasts 18 clocks on the pin instead of 16. Between transfers the pin keeps the last level it was given.

If the byte is rewritten while a transfer is still shifting, one of two policies applies. When stalling is enabled, the pin freezes and the old transfer's timing runs to its end before the new byte starts. When stalling is disabled, the old transfer is dropped and the new byte starts at once. A busy flag covers the whole transfer, and a one-cycle done pulse marks its end.

Top module: `serial_shifter`

## Requirements
- R1: While reset is held, `sout`, `busy` and `done` are all 0.
- R2: A write sampled at clock edge 0 puts bit 7 of the byte on `sout` after edge 2. Before that edge `sout` keeps its previous level.
- R3: Bits leave in the order bit 7 down to bit 0, and each one stays on `sout` for exactly two clock cycles. Step j (counting from 0) appears after edge 2+2j.
- R4: With `quirk_en`=1 the transfer makes nine steps. The ninth step, after edge 18, shows bit 7 again, and the shifting time is 18 cycles.
- R5: With `quirk_en`=0 the transfer makes eight steps, and the shifting time is 16 cycles.
- R6: After the last step, `sout` keeps its value until the first bit of the next transfer. That value is bit 0 with the quirk off and bit 7 with it on.
- R7: `busy` is 1 from the cycle after the write up to and including edge 2N+1, where N is the number of steps. It falls after edge 2N+2. `done` is 1 for exactly the one cycle that follows edge 2N+2.
- R8: With `stall_en`=1, a write during shifting freezes `sout` at its current level. The old transfer's step count runs to its end, and no `done` pulse is given for it. The new byte's first bit then appears two edges after that end, and `busy` stays 1 throughout.
- R9: With `stall_en`=0, a write during shifting drops the old transfer. The new byte's first bit appears two edges after the write, and `sout` holds its level in between.
- R10: A write during the start latency restarts the latency with the new byte, whatever the setting of `stall_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to transmit |
| quirk_en | input | 1 | Enables the ninth step |
| stall_en | input | 1 | Rewrite policy during shifting: 1 stalls, 0 restarts |
| sout | output | 1 | Serial output |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions take it that `quirk_en` and `stall_en` stay constant for the length of a transfer. They also take it that no write lands on the very edge where a transfer ends. Each stimulus sequence therefore sets both mode inputs together with its first write and leaves them alone until `busy` has fallen. Second writes are placed only at edges inside the latency or inside the shifting window. The sweep then sends every byte value in both quirk settings, and a set of rewrite cases covers both policies.

// File: rtl/serial_shifter_pkg.sv
package serial_shifter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_SHIFT = 2'd2
  } sr_state_e;
endpackage

// File: rtl/serial_shifter_seq.sv
module serial_shifter_seq
  import serial_shifter_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int START_LAT = 2,
  parameter int BIT_CYC   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic quirk_en,
  input  logic stall_en,
  output logic fire,
  output logic freeze,
  output logic load_new,
  output logic load_pend,
  output logic cap_pend,
  output logic busy,
  output logic done
);
  localparam int CYC_MAX = (START_LAT > BIT_CYC) ? START_LAT : BIT_CYC;
  localparam int CYC_W   = $clog2(CYC_MAX + 1);
  localparam int STEP_W  = $clog2(WIDTH + 2);

  sr_state_e         state_q, state_n;
  logic [CYC_W-1:0]  cyc_q, cyc_n;
  logic [STEP_W-1:0] step_q, step_n, last_step;
  logic              pend_q, pend_n, frz_q, frz_n, done_n;

  assign last_step = quirk_en ? STEP_W'(WIDTH + 1) : STEP_W'(WIDTH);
  assign freeze    = frz_q | (wr_en & stall_en & (state_q == ST_SHIFT));

  always_comb begin
    state_n   = state_q;
    cyc_n     = cyc_q;
    step_n    = step_q;
    pend_n    = pend_q;
    frz_n     = frz_q;
    done_n    = 1'b0;
    fire      = 1'b0;
    load_new  = 1'b0;
    load_pend = 1'b0;
    cap_pend  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (wr_en) begin
          state_n  = ST_START;
          cyc_n    = '0;
          load_new = 1'b1;
        end
      end
      ST_START: begin
        if (wr_en) begin
          cyc_n    = '0;
          load_new = 1'b1;
        end else if (cyc_q == CYC_W'(START_LAT - 1)) begin
          state_n = ST_SHIFT;
          cyc_n   = '0;
          step_n  = STEP_W'(1);
          fire    = 1'b1;
        end else begin
          cyc_n = cyc_q + CYC_W'(1);
        end
      end
      ST_SHIFT: begin
        if (wr_en && !stall_en) begin
          state_n  = ST_START;
          cyc_n    = '0;
          load_new = 1'b1;
          pend_n   = 1'b0;
          frz_n    = 1'b0;
        end else begin
          if (wr_en) begin
            cap_pend = 1'b1;
            pend_n   = 1'b1;
            frz_n    = 1'b1;
          end
          if (cyc_q == CYC_W'(BIT_CYC - 1)) begin
            if (step_q == last_step) begin
              cyc_n  = '0;
              pend_n = 1'b0;
              frz_n  = 1'b0;
              if (wr_en) begin
                state_n  = ST_START;
                load_new = 1'b1;
                cap_pend = 1'b0;
              end else if (pend_q) begin
                state_n   = ST_START;
                load_pend = 1'b1;
              end else begin
                state_n = ST_IDLE;
                done_n  = 1'b1;
              end
            end else begin
              step_n = step_q + STEP_W'(1);
              cyc_n  = '0;
              fire   = 1'b1;
            end
          end else begin
            cyc_n = cyc_q + CYC_W'(1);
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      step_q  <= '0;
      pend_q  <= 1'b0;
      frz_q   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_n;
      cyc_q   <= cyc_n;
      step_q  <= step_n;
      pend_q  <= pend_n;
      frz_q   <= frz_n;
      busy    <= (state_n != ST_IDLE);
      done    <= done_n;
    end
  end
endmodule

// File: rtl/serial_shifter_data.sv
module serial_shifter_data #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             load_new,
  input  logic             load_pend,
  input  logic             cap_pend,
  input  logic             fire,
  input  logic             freeze,
  output logic             sout
);
  logic [WIDTH-1:0] shreg_q, pend_q;
  logic             step;

  assign step = fire & ~freeze;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      pend_q  <= '0;
      sout    <= 1'b0;
    end else begin
      if (cap_pend)
        pend_q <= wr_data;
      if (load_new)
        shreg_q <= wr_data;
      else if (load_pend)
        shreg_q <= pend_q;
      else if (step)
        shreg_q <= {shreg_q[WIDTH-2:0], shreg_q[WIDTH-1]};
      if (step)
        sout <= shreg_q[WIDTH-1];
    end
  end
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
  parameter int WIDTH     = 8,
  parameter int START_LAT = 2,
  parameter int BIT_CYC   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             quirk_en,
  input  logic             stall_en,
  output logic             sout,
  output logic             busy,
  output logic             done
);
  logic fire, freeze, load_new, load_pend, cap_pend;

  serial_shifter_seq #(
    .WIDTH(WIDTH), .START_LAT(START_LAT), .BIT_CYC(BIT_CYC)
  ) seq_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .quirk_en(quirk_en),
    .stall_en(stall_en), .fire(fire), .freeze(freeze),
    .load_new(load_new), .load_pend(load_pend), .cap_pend(cap_pend),
    .busy(busy), .done(done)
  );

  serial_shifter_data #(
    .WIDTH(WIDTH)
  ) data_i (
    .clk(clk), .rst(rst), .wr_data(wr_data), .load_new(load_new),
    .load_pend(load_pend), .cap_pend(cap_pend), .fire(fire),
    .freeze(freeze), .sout(sout)
  );
endmodule

// File: rtl/serial_shifter_chk.sv
module serial_shifter_chk #(
  parameter int WIDTH     = 8,
  parameter int START_LAT = 2,
  parameter int BIT_CYC   = 2
) (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic sout,
  input logic busy,
  input logic done
);
  localparam int LIMIT = 2 * (START_LAT + BIT_CYC * (WIDTH + 1)) + 2;
  localparam int CNT_W = $clog2(LIMIT + 2);

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || wr_en)
      busy_cnt <= '0;
    else if (busy && busy_cnt != CNT_W'(LIMIT + 1))
      busy_cnt <= busy_cnt + CNT_W'(1);
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!busy && !done)); // R1
  AST_START_LATENCY: assert property (@(posedge clk) disable iff (rst) $rose(busy) |=> $stable(sout)); // R2
  AST_BIT_PAIR: assert property (@(posedge clk) disable iff (rst) !$stable(sout) |=> $stable(sout)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!busy && !wr_en) |=> $stable(sout)); // R6
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy))); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R7
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst) busy |-> (busy_cnt <= CNT_W'(LIMIT))); // R8
endmodule

bind serial_shifter serial_shifter_chk #(
  .WIDTH(WIDTH), .START_LAT(START_LAT), .BIT_CYC(BIT_CYC)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .sout(sout), .busy(busy), .done(done)
);

// File: tb/serial_shifter_tb.sv
module serial_shifter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       quirk_en = 1'b0;
  logic       stall_en = 1'b0;
  logic       sout, busy, done;
  logic       cur_out = 1'b0;
  int         n_chk = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_shifter dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .quirk_en(quirk_en), .stall_en(stall_en),
    .sout(sout), .busy(busy), .done(done)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected level kp edges after a load: previous level during latency,
  // then bits 7..0 (and bit 7 again in quirk mode), then hold the last one.
  function automatic logic exp_bit(logic [7:0] d, logic q, logic prev, int kp);
    int n = q ? 9 : 8;
    int j;
    if (kp < 2) return prev;
    j = kp / 2 - 1;
    if (j >= n) j = n - 1;
    return (j < 8) ? d[7 - j] : d[7];
  endfunction

  // k2 = 0: one write of a; otherwise a second write of b sampled at edge k2
  task automatic run_seq(input string tag, input logic [7:0] a, input logic [7:0] b,
                         input logic q, input logic st, input int k2);
    int n = q ? 9 : 8;
    int s, e;
    logic f;
    logic [7:0] bb;
    if (k2 == 0) begin
      bb = a; s = 0; f = cur_out;
    end else begin
      bb = b;
      f  = exp_bit(a, q, cur_out, k2 - 1);
      s  = (st && k2 >= 2) ? 2 * n + 2 : k2;
    end
    e = s + 2 * n + 2;
    @(negedge clk);
    wr_en = 1'b1; wr_data = a; quirk_en = q; stall_en = st;
    for (int k = 0; k <= e + 1; k++) begin
      logic ex;
      @(posedge clk);
      @(negedge clk);
      if (k >= 1) begin
        if (k < k2) ex = exp_bit(a, q, cur_out, k);
        else if (k < s) ex = f;
        else ex = exp_bit(bb, q, f, k - s);
        check({tag, " R3 R4 R5 sout"}, int'(sout), int'(ex));
        check({tag, " R7 busy"}, int'(busy), int'(k < e));
        check({tag, " R7 done"}, int'(done), int'(k == e));
      end
      wr_en   = (k2 != 0) && (k == k2 - 1);
      wr_data = b;
    end
    cur_out = exp_bit(bb, q, f, e);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog R7: actual no completion expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 sout", int'(sout), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 R6: every byte, both step counts
    for (int q = 0; q < 2; q++)
      for (int d = 0; d < 256; d++)
        run_seq("R2 R6", 8'(d), 8'h00, q[0], 1'b0, 0);

    // R8: stalled rewrite at even and odd edges
    run_seq("R8", 8'hB4, 8'h5A, 1'b1, 1'b1, 6);
    run_seq("R8", 8'h3C, 8'hC3, 1'b0, 1'b1, 9);
    run_seq("R8", 8'h81, 8'h7E, 1'b1, 1'b1, 17);

    // R9: restart on rewrite
    run_seq("R9", 8'hB4, 8'h5A, 1'b1, 1'b0, 6);
    run_seq("R9", 8'h0F, 8'hF0, 1'b0, 1'b0, 11);

    // R10: rewrite during latency
    run_seq("R10", 8'hFF, 8'h01, 1'b0, 1'b1, 1);
    run_seq("R10", 8'h00, 8'hAA, 1'b1, 1'b0, 1);

    // R6: hold across idle gap
    repeat (5) @(negedge clk);
    check("R6 idle hold", int'(sout), int'(cur_out));
    finish_run();
  end
endmodule